// File: doc/BRIEF.md
# Conditional Return Stack Unit

This block holds the hardware call/return stack of a small accumulator CPU and works out the next instruction pointer for flow-control instructions. Each cycle the core presents an operation (step, call or return), a 3-bit return-type code, the carry and sign flags, the 8-bit accumulator and the current instruction pointer. A call needs a target address as well. The block returns the instruction pointer for the next cycle and a taken indication in the same cycle. The stack itself updates on the clock edge.

A return is predicated on a status-flag condition. When the condition holds, the top entry is popped and execution resumes at that address. When it does not hold, the stack is untouched and the pointer advances by one like any other sequential instruction. A call stores the address after the call and jumps to the target in one cycle. Pushing onto a full stack and popping an empty one are recorded in sticky flags that stay set until reset.

Top module: `retstk_unit`

## Requirements
- R1: The return-type code `rtype_i` selects the condition: 000 always, 001 carry set, 010 carry clear, 011 zero set, 100 zero clear, 101 sign set. Codes 110 and 111 never take.
- R2: The zero condition is true exactly when `acc_i` equals 8'h00.
- R3: A return (`op_i`=10) whose condition holds on a non-empty stack drives `next_ip_o` with the top entry and `taken_o`=1, and removes that entry at the clock edge.
- R4: A return whose condition fails leaves the stack unchanged and drives `next_ip_o` = `ip_i`+1 (modulo 2^16) with `taken_o`=0.
- R5: Operation codes 00 (step) and 11 (idle) drive `next_ip_o` = `ip_i`+1 (modulo 2^16) with `taken_o`=0 and leave the stack unchanged.
- R6: A call (`op_i`=01) drives `next_ip_o` = `target_i` and `taken_o`=1, and pushes `ip_i`+1 (modulo 2^16) at the same clock edge.
- R7: A call made while 8 entries are held still jumps to the target, but it stores nothing and the stack is unchanged. `overflow_o` rises after that edge and stays high until reset.
- R8: A return whose condition holds on an empty stack drives `next_ip_o` = `ip_i` with `taken_o`=0. `underflow_o` rises after that edge and stays high until reset.
- R9: Entries come back in last-in, first-out order.
- R10: After reset the stack is empty and both `overflow_o` and `underflow_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 00 step, 01 call, 10 return, 11 idle |
| rtype_i | input | 3 | Return-type condition code |
| carry_i | input | 1 | Carry status flag |
| sign_i | input | 1 | Sign status flag |
| acc_i | input | 8 | Accumulator value, used for the zero condition |
| ip_i | input | 16 | Current instruction pointer |
| target_i | input | 16 | Call target address |
| next_ip_o | output | 16 | Instruction pointer for the next cycle |
| taken_o | output | 1 | Pointer loaded from a call target or a popped entry |
| overflow_o | output | 1 | Sticky: a call was made on a full stack |
| underflow_o | output | 1 | Sticky: a return with a true condition was made on an empty stack |

## Verification
The assertions assume that `op_i` and `rtype_i` carry known values in every cycle after reset. They assume nothing about how operations follow one another, so any mix of calls and returns is legal, including calls on a full stack and returns on an empty one. The bench drives every input at the falling edge from fully defined values. Its random phase draws operation codes, every return type and flag values over their whole range, and it sets the accumulator to zero half the time so that both outcomes of the zero conditions occur often.

// File: rtl/retstk_pkg.sv
package retstk_pkg;

  localparam logic [1:0] OP_STEP = 2'b00;
  localparam logic [1:0] OP_CALL = 2'b01;
  localparam logic [1:0] OP_RET  = 2'b10;
  localparam logic [1:0] OP_IDLE = 2'b11;

  localparam logic [2:0] RT_ALWAYS = 3'd0;
  localparam logic [2:0] RT_CSET   = 3'd1;
  localparam logic [2:0] RT_CCLR   = 3'd2;
  localparam logic [2:0] RT_ZSET   = 3'd3;
  localparam logic [2:0] RT_ZCLR   = 3'd4;
  localparam logic [2:0] RT_SSET   = 3'd5;

  // Condition decode for returns; reserved codes never take.
  function automatic logic cond_met(input logic [2:0] rt, input logic c,
                                    input logic z, input logic s);
    logic r;
    case (rt)
      RT_ALWAYS: r = 1'b1;
      RT_CSET:   r = c;
      RT_CCLR:   r = ~c;
      RT_ZSET:   r = z;
      RT_ZCLR:   r = ~z;
      RT_SSET:   r = s;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/retstk_cond.sv
module retstk_cond #(
  parameter int ACC_W = 8
) (
  input  logic [2:0]       rtype_i,
  input  logic             carry_i,
  input  logic             sign_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic             zero_o,
  output logic             met_o
);
  import retstk_pkg::*;

  always_comb begin
    zero_o = (acc_i == '0);
    met_o  = cond_met(rtype_i, carry_i, zero_o, sign_i);
  end

endmodule

// File: rtl/retstk_lifo.sv
module retstk_lifo #(
  parameter int AW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] mem [DEPTH];
  logic [CW-1:0] count;
  logic [DEPTH-1:0] wr_sel;
  logic push_ok, pop_ok;
  logic [IW-1:0] top_idx;

  assign full_o  = (count == CW'(DEPTH));
  assign empty_o = (count == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign top_idx = IW'(count - 1'b1);
  assign count_o = count;

  // One write strobe per slot, decoded from the fill level.
  for (genvar g = 0; g < DEPTH; g++) begin : g_sel
    assign wr_sel[g] = push_ok & (count == CW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (wr_sel[i]) mem[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (push_ok) count <= count + 1'b1;
    else if (pop_ok)  count <= count - 1'b1;
  end

  assign rdata_o = empty_o ? '0 : mem[top_idx];

endmodule

// File: rtl/retstk_nextpc.sv
module retstk_nextpc #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ip_i,
  input  logic [AW-1:0] target_i,
  input  logic [AW-1:0] popped_i,
  input  logic          call_i,
  input  logic          pop_i,
  input  logic          hold_i,
  output logic [AW-1:0] seq_ip_o,
  output logic [AW-1:0] next_ip_o
);
  function automatic logic [AW-1:0] ip_inc(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  assign seq_ip_o = ip_inc(ip_i);

  always_comb begin
    if (call_i)      next_ip_o = target_i;
    else if (pop_i)  next_ip_o = popped_i;
    else if (hold_i) next_ip_o = ip_i;
    else             next_ip_o = seq_ip_o;
  end

endmodule

// File: rtl/retstk_unit.sv
module retstk_unit #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op_i,
  input  logic [2:0]       rtype_i,
  input  logic             carry_i,
  input  logic             sign_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [AW-1:0]    ip_i,
  input  logic [AW-1:0]    target_i,
  output logic [AW-1:0]    next_ip_o,
  output logic             taken_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  import retstk_pkg::*;
  localparam int CW = $clog2(DEPTH+1);

  logic          zero_w, met_w;
  logic          call_ev, ret_req, ret_fire, pop_ev, ovf_ev, unf_ev;
  logic [AW-1:0] popped_w, seq_ip_w;
  logic [CW-1:0] stk_count;
  logic          stk_full, stk_empty;
  logic          ovf_q, unf_q;

  retstk_cond #(.ACC_W(ACC_W)) u_cond (
    .rtype_i (rtype_i),
    .carry_i (carry_i),
    .sign_i  (sign_i),
    .acc_i   (acc_i),
    .zero_o  (zero_w),
    .met_o   (met_w)
  );

  assign call_ev  = (op_i == OP_CALL);
  assign ret_req  = (op_i == OP_RET);
  assign ret_fire = ret_req & met_w;
  assign pop_ev   = ret_fire & ~stk_empty;
  assign unf_ev   = ret_fire & stk_empty;
  assign ovf_ev   = call_ev & stk_full;

  retstk_lifo #(.AW(AW), .DEPTH(DEPTH)) u_lifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (call_ev),
    .pop_i   (pop_ev),
    .wdata_i (seq_ip_w),
    .rdata_o (popped_w),
    .count_o (stk_count),
    .full_o  (stk_full),
    .empty_o (stk_empty)
  );

  retstk_nextpc #(.AW(AW)) u_npc (
    .ip_i      (ip_i),
    .target_i  (target_i),
    .popped_i  (popped_w),
    .call_i    (call_ev),
    .pop_i     (pop_ev),
    .hold_i    (unf_ev),
    .seq_ip_o  (seq_ip_w),
    .next_ip_o (next_ip_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (ovf_ev) ovf_q <= 1'b1;
      if (unf_ev) unf_q <= 1'b1;
    end
  end

  assign taken_o     = call_ev | pop_ev;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

endmodule

// File: rtl/retstk_chk.sv
module retstk_chk #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH+1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    op_i,
  input logic [AW-1:0] ip_i,
  input logic [AW-1:0] target_i,
  input logic [AW-1:0] next_ip_o,
  input logic          taken_o,
  input logic          overflow_o,
  input logic          underflow_o,
  input logic [CW-1:0] stk_count
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  AST_CALL_JUMPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b01) |-> (taken_o && next_ip_o == target_i)); // R6
  AST_CALL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b01 && stk_count != FULLV) |=> stk_count == $past(stk_count) + 1'b1); // R6
  AST_TAKEN_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b10 && taken_o) |=> stk_count == $past(stk_count) - 1'b1); // R3
  AST_UNTAKEN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b10 && !taken_o) |=> stk_count == $past(stk_count)); // R4
  AST_UNTAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b10 && !taken_o && stk_count != '0) |-> next_ip_o == ip_i + 1'b1); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    stk_count <= FULLV); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o); // R7
  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b01 && stk_count == FULLV) |=> overflow_o && stk_count == FULLV); // R7
  AST_UNF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b10 && stk_count == '0 && next_ip_o == ip_i) |=> underflow_o); // R8
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> underflow_o); // R8

endmodule

bind retstk_unit retstk_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_i        (op_i),
  .ip_i        (ip_i),
  .target_i    (target_i),
  .next_ip_o   (next_ip_o),
  .taken_o     (taken_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o),
  .stk_count   (stk_count)
);

// File: tb/tb_retstk_unit.sv
module tb_retstk_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  localparam int MDEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [2:0]  rtype_i = 3'd0;
  logic        carry_i = 1'b0, sign_i = 1'b0;
  logic [7:0]  acc_i = 8'h00;
  logic [15:0] ip_i = 16'h0, target_i = 16'h0;
  logic [15:0] next_ip_o;
  logic        taken_o, overflow_o, underflow_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] m_stk [MDEPTH];
  int m_cnt = 0;
  bit m_ovf = 0, m_unf = 0;

  retstk_unit dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Fields: op(2) rtype(3) c s acc(8) ip(16) tgt(16) exp_ip(16) exp_taken(1)
  localparam logic [63:0] VEC [NVEC] = '{
    {2'b01,3'd0,1'b0,1'b0,8'h00,16'h0010,16'h0100,16'h0100,1'b1}, // R6 call
    {2'b01,3'd0,1'b0,1'b0,8'h00,16'h0100,16'h0200,16'h0200,1'b1}, // R6 nested call
    {2'b10,3'd1,1'b0,1'b0,8'h11,16'h0200,16'h0000,16'h0201,1'b0}, // R1 C with c=0
    {2'b10,3'd1,1'b1,1'b0,8'h11,16'h0201,16'h0000,16'h0101,1'b1}, // R9 top entry first
    {2'b10,3'd2,1'b1,1'b0,8'h11,16'h0101,16'h0000,16'h0102,1'b0}, // R1 NC with c=1
    {2'b10,3'd3,1'b0,1'b0,8'h05,16'h0102,16'h0000,16'h0103,1'b0}, // R2 Z, acc!=0
    {2'b10,3'd4,1'b0,1'b0,8'h05,16'h0103,16'h0000,16'h0011,1'b1}, // R2 NZ, acc!=0
    {2'b01,3'd0,1'b0,1'b0,8'h00,16'h0020,16'h0300,16'h0300,1'b1}, // R6
    {2'b10,3'd5,1'b0,1'b0,8'h00,16'h0300,16'h0000,16'h0301,1'b0}, // R1 S with s=0
    {2'b10,3'd6,1'b1,1'b1,8'h00,16'h0301,16'h0000,16'h0302,1'b0}, // R1 reserved 110
    {2'b10,3'd7,1'b1,1'b1,8'h00,16'h0302,16'h0000,16'h0303,1'b0}, // R1 reserved 111
    {2'b11,3'd0,1'b0,1'b0,8'h00,16'h0303,16'h0555,16'h0304,1'b0}, // R5 idle
    {2'b10,3'd3,1'b0,1'b0,8'h00,16'h0304,16'h0000,16'h0021,1'b1}, // R2 Z, acc==0
    {2'b00,3'd1,1'b1,1'b0,8'h00,16'hFFFF,16'h1234,16'h0000,1'b0}  // R5 wrap
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit model_cond(input logic [2:0] rt, input logic c,
                                    input logic [7:0] a, input logic s);
    bit z = (a == 8'h00);
    if (rt == 3'd0) return 1'b1;
    if (rt == 3'd1) return c == 1'b1;
    if (rt == 3'd2) return c == 1'b0;
    if (rt == 3'd3) return z;
    if (rt == 3'd4) return !z;
    if (rt == 3'd5) return s == 1'b1;
    return 1'b0;
  endfunction

  // Drive one operation at the falling edge, compare outputs, advance the model.
  task automatic apply(input logic [1:0] op, input logic [2:0] rt, input logic c,
                       input logic s, input logic [7:0] a, input logic [15:0] ip,
                       input logic [15:0] tgt, input bit use_tab,
                       input logic [15:0] tab_ip, input bit tab_t);
    logic [15:0] e_ip;
    bit e_t;
    string req;
    @(negedge clk);
    check(overflow_o == m_ovf, "R7", "overflow flag", 16'(overflow_o), 16'(m_ovf));
    check(underflow_o == m_unf, "R8", "underflow flag", 16'(underflow_o), 16'(m_unf));
    op_i = op; rtype_i = rt; carry_i = c; sign_i = s; acc_i = a;
    ip_i = ip; target_i = tgt;
    #1;
    if (op == 2'b01) begin
      req = (m_cnt == MDEPTH) ? "R7" : "R6";
      e_ip = tgt; e_t = 1;
      if (m_cnt < MDEPTH) begin m_stk[m_cnt] = ip + 16'd1; m_cnt++; end
      else m_ovf = 1;
    end else if (op == 2'b10 && model_cond(rt, c, a, s)) begin
      if (m_cnt == 0) begin req = "R8"; e_ip = ip; e_t = 0; m_unf = 1; end
      else begin req = "R3"; m_cnt--; e_ip = m_stk[m_cnt]; e_t = 1; end
    end else begin
      req = (op == 2'b10) ? "R4" : "R5";
      e_ip = ip + 16'd1; e_t = 0;
    end
    if (use_tab) begin
      check(e_ip == tab_ip && e_t == tab_t, "R1", "table/model agreement", e_ip, tab_ip);
    end
    check(next_ip_o == e_ip, req, "next_ip", next_ip_o, e_ip);
    check(taken_o == e_t, req, "taken", 16'(taken_o), 16'(e_t));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; op_i = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_cnt = 0; m_ovf = 0; m_unf = 0;
    #1;
    // R10: flags clear after reset
    check(overflow_o == 1'b0 && underflow_o == 1'b0, "R10", "flags after reset",
          {14'd0, overflow_o, underflow_o}, 16'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10: empty stack after reset, so a true return holds the pointer
    apply(2'b00, 3'd0, 1'b0, 1'b0, 8'h00, 16'h0040, 16'h0, 0, 16'h0, 0);
    apply(2'b10, 3'd4, 1'b0, 1'b0, 8'h00, 16'h0041, 16'h0, 0, 16'h0, 0); // R4 false on empty: no underflow
    apply(2'b10, 3'd0, 1'b0, 1'b0, 8'h00, 16'h0042, 16'h0, 0, 16'h0, 0); // R8 and R10

    do_reset();
    for (int i = 0; i < NVEC; i++) begin
      logic [63:0] v = VEC[i];
      apply(v[63:62], v[61:59], v[58], v[57], v[56:49], v[48:33], v[32:17], 1, v[16:1], v[0]);
    end

    // R7: fill to capacity, then one more call; R9: drain in reverse order
    do_reset();
    for (int i = 0; i < MDEPTH + 1; i++)
      apply(2'b01, 3'd0, 1'b0, 1'b0, 8'h00, 16'h1000 + 16'(i * 16), 16'h2000 + 16'(i), 0, 16'h0, 0);
    for (int i = 0; i < MDEPTH + 1; i++)
      apply(2'b10, 3'd0, 1'b0, 1'b0, 8'h00, 16'h3000 + 16'(i), 16'h0, 0, 16'h0, 0);
    apply(2'b00, 3'd0, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0, 0, 16'h0, 0);
    // R6: call from the top of the address space pushes a wrapped return address
    apply(2'b01, 3'd0, 1'b0, 1'b0, 8'h00, 16'hFFFF, 16'h0700, 0, 16'h0, 0);
    apply(2'b10, 3'd5, 1'b0, 1'b1, 8'h00, 16'h0700, 16'h0, 0, 16'h0, 0);

    // Random mix against the model: every return type, random flags
    do_reset();
    for (int i = 0; i < 600; i++) begin
      logic [1:0] op = 2'($urandom % 4);
      logic [7:0] a = ($urandom % 2 == 0) ? 8'h00 : 8'($urandom);
      apply(op, 3'($urandom % 8), 1'($urandom), 1'($urandom), a,
            16'($urandom), 16'($urandom), 0, 16'h0, 0);
    end
    apply(2'b00, 3'd0, 1'b0, 1'b0, 8'h00, 16'h0, 16'h0, 0, 16'h0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule